// File: doc/BRIEF.md
# Pulse-Clocked Serial Digit Output Mux

This block sits after a tone decoder and returns a 4-bit digit code to a host controller over a single output pin. When the steering input rises, the block becomes armed. The host then sends four acknowledge pulses. The first rising edge captures the digit and places bit 0 on the pin. The next three rising edges present bits 1, 2 and 3, so the least significant bit comes first.

The same pin carries an energy-detect level at all other times. It shows the energy level before the first rising edge of a transfer and after the falling edge of the fourth pulse. Powerdown forces the pin low and abandons any transfer that is in progress.

The acknowledge and steering lines are asynchronous to the system clock. A synchronizer of `SYNC_STAGES` flops brings each one into the clock domain, and edges are detected on the synchronized value. For this reason the acknowledge pulses must be much slower than the system clock.

Top module: `digit_shift_mux`

## Requirements
- R1: After a steering rise, the first acknowledge rising edge captures `digit_in` and drives its bit 0 on `sd_out`.
- R2: The second, third and fourth acknowledge rising edges of a transfer drive bits 1, 2 and 3 of the captured digit, in that order.
- R3: Outside the interval from the first rising edge to the fourth falling edge, `sd_out` equals `energy_in`. Inside that interval it shows the data bit, whatever the level of `energy_in`.
- R4: A change of `digit_in` after the capture does not alter the bits of the transfer in progress.
- R5: Acknowledge pulses after the fourth are ignored, and `sd_out` keeps following `energy_in`, until steering rises again.
- R6: A steering rise during an unfinished transfer does not arm a new capture. The remaining pulses shift out the rest of the old digit, and a pulse after that is ignored.
- R7: While `pwdn` is high, `sd_out` is low and any armed or partial transfer is dropped. After `pwdn` is released, pulses are ignored until the next steering rise.
- R8: After reset the block is unarmed and `sd_out` follows `energy_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| steer_in | input | 1 | Steering level from the decoder (asynchronous) |
| digit_in | input | 4 | Decoded digit code |
| ack_in | input | 1 | Acknowledge pulse line (asynchronous, idles low) |
| energy_in | input | 1 | Energy-detect level |
| pwdn | input | 1 | Powerdown, active high |
| sd_out | output | 1 | Shared serial data / energy pin |

## Verification
The assertions check the following properties on every cycle:
- the pin is held low in powerdown;
- the pin follows the energy input whenever no transfer is open;
- the pulse counter never passes four;
- the captured word changes only on an acknowledge rise;
- a capture loads the digit;
- a steering rise inside an open transfer leaves the block unarmed;
- a pulse that arrives unarmed starts nothing.

The bench scenarios show the facts that span many pulses:
- the order in which the bits leave the pin;
- that late changes of the digit are ignored;
- that surplus pulses are ignored;
- how an interrupted transfer recovers after a second steering rise or after powerdown.

// File: rtl/digit_shift_mux.sv
module digit_shift_mux #(
  parameter int BITS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            steer_in,
  input  logic [BITS-1:0] digit_in,
  input  logic            ack_in,
  input  logic            energy_in,
  input  logic            pwdn,
  output logic            sd_out
);
  localparam int CNT_W = $clog2(BITS + 1);

  logic [SYNC_STAGES:0] ack_q, steer_q;
  logic                 ack_rise, ack_fall, steer_rise;
  logic                 armed, window, last;
  logic [CNT_W-1:0]     cnt;
  logic [BITS-1:0]      shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_q   <= '0;
      steer_q <= '0;
    end else begin
      ack_q   <= {ack_q[SYNC_STAGES-1:0], ack_in};
      steer_q <= {steer_q[SYNC_STAGES-1:0], steer_in};
    end

  assign ack_rise   = ack_q[SYNC_STAGES-1] & ~ack_q[SYNC_STAGES];
  assign ack_fall   = ~ack_q[SYNC_STAGES-1] & ack_q[SYNC_STAGES];
  assign steer_rise = steer_q[SYNC_STAGES-1] & ~steer_q[SYNC_STAGES];
  assign window     = (cnt != '0);
  assign last       = (cnt == CNT_W'(BITS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (pwdn) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      if (steer_rise && !window) armed <= 1'b1;
      if (ack_rise) begin
        if (!window && armed) begin
          shreg <= digit_in;
          cnt   <= CNT_W'(1);
          armed <= 1'b0;
        end else if (window && !last) begin
          shreg <= shreg >> 1;
          cnt   <= cnt + 1'b1;
        end
      end else if (ack_fall && last) begin
        cnt <= '0;
      end
    end

  assign sd_out = pwdn ? 1'b0 : (window ? shreg[0] : energy_in);
endmodule

module digit_shift_mux_chk #(
  parameter int BITS  = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwdn,
  input logic             energy_in,
  input logic             sd_out,
  input logic [BITS-1:0]  digit_in,
  input logic             ack_rise,
  input logic             steer_rise,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [BITS-1:0]  shreg
);
  // R1
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n || pwdn)
    (ack_rise && armed && cnt == '0) |=> (cnt == CNT_W'(1) && shreg == $past(digit_in)));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BITS));
  // R3
  idle_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwdn && cnt == '0) |-> sd_out == energy_in);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !ack_rise) |=> $stable(shreg));
  // R5
  extra_chk: assert property (@(posedge clk) disable iff (!rst_n || pwdn)
    (cnt == '0 && !armed && ack_rise) |=> cnt == '0);
  // R6
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n || pwdn)
    (cnt != '0 && steer_rise) |=> !armed);
  // R7
  pwdn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |-> !sd_out);
endmodule

bind digit_shift_mux digit_shift_mux_chk #(.BITS(BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwdn(pwdn), .energy_in(energy_in), .sd_out(sd_out),
  .digit_in(digit_in), .ack_rise(ack_rise), .steer_rise(steer_rise),
  .armed(armed), .cnt(cnt), .shreg(shreg)
);

// File: tb/test_digit_shift_mux.sv
module test_digit_shift_mux;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       steer = 1'b0, ack = 1'b0, energy = 1'b0, pwdn = 1'b0;
  logic [3:0] digit = '0;
  logic       sd;
  int         checks = 0, fails = 0;

  always #5 clk = ~clk;

  digit_shift_mux i_digit_shift_mux (
    .clk(clk), .rst_n(rst_n), .steer_in(steer), .digit_in(digit),
    .ack_in(ack), .energy_in(energy), .pwdn(pwdn), .sd_out(sd)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: sd_out=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic arm();
    steer = 1'b0; tick(4);
    steer = 1'b1; tick(6);
  endtask

  task automatic ack_hi(); ack = 1'b1; tick(6); endtask
  task automatic ack_lo(); ack = 1'b0; tick(6); endtask

  task automatic shift_bits(input logic [3:0] d, input int first, input int last, input string req);
    for (int i = first; i <= last; i++) begin
      energy = ~d[i];
      ack_hi();
      chk(req, sd, d[i]);
      ack_lo();
      if (i < 3) chk(req, sd, d[i]);
    end
  endtask

  task automatic idle_pulse(input string req);
    for (int e = 0; e < 2; e++) begin
      energy = e[0];
      ack_hi();
      chk(req, sd, energy);
      ack_lo();
      chk(req, sd, energy);
    end
  endtask

  function automatic logic [3:0] pick_code(input int k);
    return 4'(k % 16);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R8 reset state follows energy
    energy = 1'b0; tick(1); chk("R8", sd, 1'b0);
    energy = 1'b1; tick(1); chk("R8", sd, 1'b1);
    idle_pulse("R8");

    // R1 R2 R3 directed codes
    foreach (digit[b]) ;
    for (int k = 0; k < 4; k++) begin
      logic [3:0] d;
      d = (k == 0) ? 4'b0001 : (k == 1) ? 4'b1010 : (k == 2) ? 4'b0000 : 4'b1111;
      digit = d;
      arm();
      shift_bits(d, 0, 3, "R1/R2");
      energy = 1'b1; tick(1); chk("R3", sd, 1'b1);
      energy = 1'b0; tick(1); chk("R3", sd, 1'b0);
    end

    // R5 surplus pulses ignored
    idle_pulse("R5");
    steer = 1'b0; tick(4);
    idle_pulse("R5");

    // R4 digit change after capture
    digit = 4'b0110; arm();
    energy = 1'b1; ack_hi(); chk("R1", sd, 1'b0);
    digit = 4'b1001;
    ack_lo();
    shift_bits(4'b0110, 1, 3, "R4");

    // R6 steering rise inside unfinished transfer
    digit = 4'b1011; arm();
    shift_bits(4'b1011, 0, 1, "R6");
    digit = 4'b0100;
    arm();
    shift_bits(4'b1011, 2, 3, "R6");
    idle_pulse("R6");
    arm();
    shift_bits(4'b0100, 0, 3, "R6");

    // R7 powerdown mid transfer
    digit = 4'b1101; arm();
    shift_bits(4'b1101, 0, 1, "R7");
    energy = 1'b1; pwdn = 1'b1; tick(1); chk("R7", sd, 1'b0);
    ack_hi(); chk("R7", sd, 1'b0); ack_lo();
    pwdn = 1'b0; tick(2); chk("R7", sd, 1'b1);
    idle_pulse("R7");
    digit = 4'b0011; arm();
    shift_bits(4'b0011, 0, 3, "R7");

    // random transfers
    for (int n = 0; n < 25; n++) begin
      logic [3:0] d;
      d = pick_code(int'($urandom));
      digit = d;
      arm();
      for (int i = 0; i < 4; i++) begin
        energy = 1'($urandom);
        ack_hi(); chk("R2", sd, d[i]);
        if ($urandom % 2 == 1) digit = 4'($urandom);
        ack_lo();
      end
      energy = 1'($urandom); tick(1); chk("R3", sd, energy);
      if ($urandom % 3 == 0) idle_pulse("R5");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule